// File: doc/BRIEF.md
# Doorbell Mailbox Register Block

This block is the device-side end of a host-to-controller mailbox. A host reaches it through a small memory-mapped register window. It loads source and destination pointers and a small outbound data buffer, then writes a command word. That write acts as a doorbell: the block latches the command, marks itself busy and sends a one-cycle pulse toward the embedded controller, which then reads the command, the pointers and the outbound buffer from dedicated output ports.

When the controller has finished, it pulses a completion input. On that pulse it also presents an error flag, an error code, its own initiator identity and the inbound buffer contents. The block captures all of these in the same cycle, drops busy and, if the accepted command asked for it, pulses a completion interrupt to the host. The host can poll the status register or wait for that pulse, and then read the inbound buffer. Indirect 32-bit accesses follow a fixed pattern. A read uses command id 2 with size 4 and the source pointer. A write uses command id 5 with size 4, the destination pointer and outbound word 0.

Top module: `mbx_doorbell`

## Requirements
- R1: After reset, every register reads zero, `host_irq` and `ctl_doorbell` are low, and the controller-facing command, pointer and buffer outputs are zero.
- R2: A write to offset 0x00 while not busy latches the command word on `ctl_cmd`, sets status bit 0 (busy), copies command bits 15:12 into status bits 7:4, and pulses `ctl_doorbell` high for exactly the one cycle after the write edge.
- R3: A write to offset 0x00 while busy is dropped: `ctl_cmd` keeps its value, no doorbell pulse occurs, and status bit 2 (overrun) is set. That bit stays set until the next accepted command write clears it.
- R4: A `ctl_done` pulse while busy clears busy and loads status bit 1 from `ctl_err`, bits 23:16 from `ctl_err_code` and bits 15:8 from `ctl_initiator`, all in the same cycle.
- R5: On an accepted completion, `host_irq` is high for one cycle if and only if bit 8 (interrupt on completion) of the accepted command was 1.
- R6: Writes to offset 0x08 and 0x0C set `ctl_src_ptr` and `ctl_dst_ptr`. Both registers read back as zero.
- R7: Aligned writes to offsets 0x80, 0x84, 0x88 and 0x8C set outbound words 0 to 3 on `ctl_wbuf` (word n at bits 32n+31:32n). Those offsets read as zero.
- R8: Aligned reads of offsets 0x90 to 0x9C return inbound words 0 to 3 as captured at the last accepted completion. Writes to them have no effect.
- R9: Writes to the status register, to unaligned or unmapped offsets, and reads of the command register or of unmapped offsets have no effect and return zero. `hst_rdata` is zero in any cycle after which no read was requested.
- R10: A `ctl_done` pulse while not busy changes no status field, no inbound word and raises no `host_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_addr | input | ADDR_W | Host byte offset into the window |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Read data, valid the cycle after `hst_rd` |
| host_irq | output | 1 | One-cycle completion interrupt to host |
| ctl_doorbell | output | 1 | One-cycle pulse to controller on accepted command |
| ctl_cmd | output | 32 | Latched command word |
| ctl_src_ptr | output | 32 | Source pointer |
| ctl_dst_ptr | output | 32 | Destination pointer |
| ctl_wbuf | output | NUM_WORDS*32 | Outbound buffer, word 0 in the low bits |
| ctl_done | input | 1 | Controller completion pulse |
| ctl_err | input | 1 | Error flag captured on completion |
| ctl_err_code | input | 8 | Error code captured on completion |
| ctl_initiator | input | 8 | Initiator id captured on completion |
| ctl_rbuf | input | NUM_WORDS*32 | Inbound buffer contents captured on completion |

## Verification
Every result of this block appears one register stage after the edge that sees the stimulus. A read's data, the doorbell pulse, the completion interrupt and any change of pointer, buffer or status all appear in the cycle after the write, read or completion edge. A read issued in the same cycle as a write or completion returns the state from before that edge. The bench applies one stimulus per cycle at the falling edge and advances a behavioural model at the rising edge. At the next falling edge it compares every output port against that model, so each check sees each result in the single cycle where it becomes due.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int MBX_WORD_W  = 32;

    // register offsets inside the host window
    localparam int OFS_COMMAND = 'h00;
    localparam int OFS_STATUS  = 'h04;
    localparam int OFS_SRC_PTR = 'h08;
    localparam int OFS_DST_PTR = 'h0C;
    localparam int OFS_OUT_BUF = 'h80;

    // command word fields that the block itself interprets
    localparam int CMD_IOC_BIT = 8;
    localparam int CMD_ID_LSB  = 12;
    localparam int CMD_ID_W    = 4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_COMMAND,
        SEL_STATUS,
        SEL_SRC,
        SEL_DST,
        SEL_OUTBUF,
        SEL_INBUF
    } mbx_sel_e;

    typedef struct packed {
        logic [7:0] spare_hi;
        logic [7:0] err_code;
        logic [7:0] initiator;
        logic [3:0] cmd_id;
        logic       spare_lo;
        logic       overrun;
        logic       err;
        logic       busy;
    } mbx_status_t;

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_WORDS = 4,
    localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output mbx_sel_e          sel,
    output logic [IDX_W-1:0]  idx
);

    localparam int BUF_BYTES   = 4 * NUM_WORDS;
    localparam int OFS_IN_BUF  = OFS_OUT_BUF + BUF_BYTES;

    logic [NUM_WORDS-1:0] out_hit;
    logic [NUM_WORDS-1:0] in_hit;

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_hit
        assign out_hit[i] = (addr == ADDR_W'(OFS_OUT_BUF + 4 * i));
        assign in_hit[i]  = (addr == ADDR_W'(OFS_IN_BUF + 4 * i));
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (out_hit[i] || in_hit[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (addr == ADDR_W'(OFS_COMMAND)) begin
            sel = SEL_COMMAND;
        end else if (addr == ADDR_W'(OFS_STATUS)) begin
            sel = SEL_STATUS;
        end else if (addr == ADDR_W'(OFS_SRC_PTR)) begin
            sel = SEL_SRC;
        end else if (addr == ADDR_W'(OFS_DST_PTR)) begin
            sel = SEL_DST;
        end else if (|out_hit) begin
            sel = SEL_OUTBUF;
        end else if (|in_hit) begin
            sel = SEL_INBUF;
        end else begin
            sel = SEL_NONE;
        end
    end

    always_comb begin
        a_r9_decode_exclusive : assert ($countones({out_hit, in_hit}) <= 1);
    end

endmodule

// File: rtl/mbx_outbuf.sv
module mbx_outbuf #(
    parameter int NUM_WORDS = 4,
    parameter int WORD_W    = 32,
    parameter int IDX_W     = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            idx,
    input  logic [WORD_W-1:0]           wdata,
    output logic [NUM_WORDS*WORD_W-1:0] words_flat
);

    logic [WORD_W-1:0] word_d [NUM_WORDS];
    logic [WORD_W-1:0] word_q [NUM_WORDS];

    always_comb begin
        for (int i = 0; i < NUM_WORDS; i++) begin
            word_d[i] = word_q[i];
            if (wr_en && (idx == IDX_W'(i))) begin
                word_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (!rst_n) begin
                word_q[i] <= '0;
            end else begin
                word_q[i] <= word_d[i];
            end
        end
    end

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_flat
        assign words_flat[i*WORD_W +: WORD_W] = word_q[i];
    end

    a_r7_hold_without_write : assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(words_flat));

endmodule

// File: rtl/mbx_inbuf.sv
module mbx_inbuf #(
    parameter int NUM_WORDS = 4,
    parameter int WORD_W    = 32,
    parameter int IDX_W     = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [NUM_WORDS*WORD_W-1:0] words_in,
    input  logic [IDX_W-1:0]            idx,
    output logic [WORD_W-1:0]           rd_word
);

    logic [WORD_W-1:0] word_d [NUM_WORDS];
    logic [WORD_W-1:0] word_q [NUM_WORDS];

    always_comb begin
        for (int i = 0; i < NUM_WORDS; i++) begin
            word_d[i] = load ? words_in[i*WORD_W +: WORD_W] : word_q[i];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (!rst_n) begin
                word_q[i] <= '0;
            end else begin
                word_q[i] <= word_d[i];
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (idx == IDX_W'(i)) begin
                rd_word = word_q[i];
            end
        end
    end

    a_r10_hold_without_load : assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(rd_word) || !$stable(idx));

endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
    import mbx_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_WORDS = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            hst_wr,
    input  logic                            hst_rd,
    input  logic [ADDR_W-1:0]               hst_addr,
    input  logic [MBX_WORD_W-1:0]           hst_wdata,
    output logic [MBX_WORD_W-1:0]           hst_rdata,
    output logic                            host_irq,
    output logic                            ctl_doorbell,
    output logic [MBX_WORD_W-1:0]           ctl_cmd,
    output logic [MBX_WORD_W-1:0]           ctl_src_ptr,
    output logic [MBX_WORD_W-1:0]           ctl_dst_ptr,
    output logic [NUM_WORDS*MBX_WORD_W-1:0] ctl_wbuf,
    input  logic                            ctl_done,
    input  logic                            ctl_err,
    input  logic [7:0]                      ctl_err_code,
    input  logic [7:0]                      ctl_initiator,
    input  logic [NUM_WORDS*MBX_WORD_W-1:0] ctl_rbuf
);

    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    typedef struct packed {
        logic                  busy;
        logic                  err;
        logic                  overrun;
        logic [7:0]            err_code;
        logic [7:0]            initiator;
        logic [MBX_WORD_W-1:0] cmd;
        logic [MBX_WORD_W-1:0] src;
        logic [MBX_WORD_W-1:0] dst;
        logic                  bell;
        logic                  irq;
        logic [MBX_WORD_W-1:0] rdata;
    } core_t;

    core_t st_d, st_q;

    mbx_sel_e          sel;
    logic [IDX_W-1:0]  idx;
    logic [MBX_WORD_W-1:0] in_word;
    mbx_status_t       status_w;
    logic              finish_ok;
    logic              outbuf_we;

    mbx_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_WORDS (NUM_WORDS)
    ) u_decode (
        .addr (hst_addr),
        .sel  (sel),
        .idx  (idx)
    );

    assign outbuf_we = hst_wr && (sel == SEL_OUTBUF);
    assign finish_ok = ctl_done && st_q.busy;

    mbx_outbuf #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (MBX_WORD_W),
        .IDX_W     (IDX_W)
    ) u_outbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (outbuf_we),
        .idx        (idx),
        .wdata      (hst_wdata),
        .words_flat (ctl_wbuf)
    );

    mbx_inbuf #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (MBX_WORD_W),
        .IDX_W     (IDX_W)
    ) u_inbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (finish_ok),
        .words_in (ctl_rbuf),
        .idx      (idx),
        .rd_word  (in_word)
    );

    always_comb begin
        status_w           = '0;
        status_w.busy      = st_q.busy;
        status_w.err       = st_q.err;
        status_w.overrun   = st_q.overrun;
        status_w.cmd_id    = st_q.cmd[CMD_ID_LSB +: CMD_ID_W];
        status_w.initiator = st_q.initiator;
        status_w.err_code  = st_q.err_code;
    end

    always_comb begin
        st_d       = st_q;
        st_d.bell  = 1'b0;
        st_d.irq   = 1'b0;
        st_d.rdata = '0;

        if (hst_rd) begin
            case (sel)
                SEL_STATUS: st_d.rdata = status_w;
                SEL_INBUF:  st_d.rdata = in_word;
                default:    st_d.rdata = '0;
            endcase
        end

        if (hst_wr) begin
            case (sel)
                SEL_COMMAND: begin
                    if (st_q.busy) begin
                        st_d.overrun = 1'b1;
                    end else begin
                        st_d.busy    = 1'b1;
                        st_d.cmd     = hst_wdata;
                        st_d.overrun = 1'b0;
                        st_d.bell    = 1'b1;
                    end
                end
                SEL_SRC: st_d.src = hst_wdata;
                SEL_DST: st_d.dst = hst_wdata;
                default: ;
            endcase
        end

        if (finish_ok) begin
            st_d.busy      = 1'b0;
            st_d.err       = ctl_err;
            st_d.err_code  = ctl_err_code;
            st_d.initiator = ctl_initiator;
            st_d.irq       = st_q.cmd[CMD_IOC_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hst_rdata    = st_q.rdata;
    assign host_irq     = st_q.irq;
    assign ctl_doorbell = st_q.bell;
    assign ctl_cmd      = st_q.cmd;
    assign ctl_src_ptr  = st_q.src;
    assign ctl_dst_ptr  = st_q.dst;

    a_r2_bell_means_busy : assert property (@(posedge clk) disable iff (!rst_n)
        ctl_doorbell |-> st_q.busy);

    a_r2_bell_one_cycle : assert property (@(posedge clk) disable iff (!rst_n)
        ctl_doorbell |=> !ctl_doorbell);

    a_r3_drop_while_busy : assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr && sel == SEL_COMMAND && st_q.busy) |=> (!ctl_doorbell && st_q.overrun && $stable(ctl_cmd)));

    a_r4_done_clears_busy : assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_done && st_q.busy) |=> !st_q.busy);

    a_r5_irq_after_finish : assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (!st_q.busy && $past(st_q.busy)));

    a_r10_idle_done_quiet : assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_done && !st_q.busy && !hst_wr) |=> (!host_irq && $stable(st_q.err) && $stable(st_q.err_code)));

endmodule

// File: tb/mbx_doorbell_bench.sv
module mbx_doorbell_bench;

    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hst_wr = 1'b0;
    logic          hst_rd = 1'b0;
    logic [7:0]    hst_addr = '0;
    logic [31:0]   hst_wdata = '0;
    logic [31:0]   hst_rdata;
    logic          host_irq;
    logic          ctl_doorbell;
    logic [31:0]   ctl_cmd;
    logic [31:0]   ctl_src_ptr;
    logic [31:0]   ctl_dst_ptr;
    logic [NW*32-1:0] ctl_wbuf;
    logic          ctl_done = 1'b0;
    logic          ctl_err = 1'b0;
    logic [7:0]    ctl_err_code = '0;
    logic [7:0]    ctl_initiator = '0;
    logic [NW*32-1:0] ctl_rbuf = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // behavioural model state
    bit          m_busy, m_err, m_ovr, m_bell, m_irq;
    logic [7:0]  m_code, m_init;
    logic [31:0] m_cmd, m_src, m_dst, m_rdata;
    logic [31:0] m_out [NW];
    logic [31:0] m_in [NW];

    always #10 clk = ~clk;

    mbx_doorbell #(.ADDR_W(8), .NUM_WORDS(NW)) u_mbx_doorbell (
        .clk (clk), .rst_n (rst_n),
        .hst_wr (hst_wr), .hst_rd (hst_rd), .hst_addr (hst_addr),
        .hst_wdata (hst_wdata), .hst_rdata (hst_rdata),
        .host_irq (host_irq), .ctl_doorbell (ctl_doorbell),
        .ctl_cmd (ctl_cmd), .ctl_src_ptr (ctl_src_ptr), .ctl_dst_ptr (ctl_dst_ptr),
        .ctl_wbuf (ctl_wbuf), .ctl_done (ctl_done), .ctl_err (ctl_err),
        .ctl_err_code (ctl_err_code), .ctl_initiator (ctl_initiator),
        .ctl_rbuf (ctl_rbuf)
    );

    function automatic logic [31:0] m_status();
        return {8'h00, m_code, m_init, m_cmd[15:12], 1'b0, m_ovr, m_err, m_busy};
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        if (a == 8'h04) return m_status();
        if (a >= 8'h90 && a < 8'hA0 && a[1:0] == 2'b00) return m_in[(a - 8'h90) >> 2];
        return 32'h0;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        logic [NW*32-1:0] exp_out;
        for (int i = 0; i < NW; i++) exp_out[i*32 +: 32] = m_out[i];
        check(tag, "hst_rdata", 128'(hst_rdata), 128'(m_rdata));
        check(tag, "ctl_doorbell", 128'(ctl_doorbell), 128'(m_bell));
        check(tag, "host_irq", 128'(host_irq), 128'(m_irq));
        check(tag, "ctl_cmd", 128'(ctl_cmd), 128'(m_cmd));
        check(tag, "ctl_src_ptr", 128'(ctl_src_ptr), 128'(m_src));
        check(tag, "ctl_dst_ptr", 128'(ctl_dst_ptr), 128'(m_dst));
        check(tag, "ctl_wbuf", 128'(ctl_wbuf), 128'(exp_out));
    endtask

    task automatic model_step(input bit wr, input bit rd, input logic [7:0] a,
                              input logic [31:0] wd, input bit dn, input bit e,
                              input logic [7:0] code, input logic [7:0] ini);
        bit busy_pre;
        busy_pre = m_busy;
        m_rdata  = rd ? m_read(a) : 32'h0;
        m_bell   = 1'b0;
        m_irq    = 1'b0;
        if (wr) begin
            if (a == 8'h00) begin
                if (busy_pre) m_ovr = 1'b1;
                else begin
                    m_busy = 1'b1; m_cmd = wd; m_ovr = 1'b0; m_bell = 1'b1;
                end
            end else if (a == 8'h08) m_src = wd;
            else if (a == 8'h0C) m_dst = wd;
            else if (a >= 8'h80 && a < 8'h90 && a[1:0] == 2'b00) m_out[(a - 8'h80) >> 2] = wd;
        end
        if (dn && busy_pre) begin
            m_busy = 1'b0; m_err = e; m_code = code; m_init = ini;
            m_irq = m_cmd[8];
            for (int i = 0; i < NW; i++) m_in[i] = ctl_rbuf[i*32 +: 32];
        end
    endtask

    task automatic op(input string tag, input bit wr, input bit rd, input logic [7:0] a,
                      input logic [31:0] wd, input bit dn = 1'b0, input bit e = 1'b0,
                      input logic [7:0] code = 8'h00, input logic [7:0] ini = 8'h00);
        hst_wr = wr; hst_rd = rd; hst_addr = a; hst_wdata = wd;
        ctl_done = dn; ctl_err = e; ctl_err_code = code; ctl_initiator = ini;
        @(posedge clk);
        model_step(wr, rd, a, wd, dn, e, code, ini);
        @(negedge clk);
        compare_all(tag);
        hst_wr = 1'b0; hst_rd = 1'b0; hst_addr = '0; hst_wdata = '0;
        ctl_done = 1'b0; ctl_err = 1'b0; ctl_err_code = '0; ctl_initiator = '0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        m_busy = 0; m_err = 0; m_ovr = 0; m_bell = 0; m_irq = 0;
        m_code = 0; m_init = 0; m_cmd = 0; m_src = 0; m_dst = 0; m_rdata = 0;
        for (int i = 0; i < NW; i++) begin m_out[i] = 0; m_in[i] = 0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare_all("R1");
        op("R1", 0, 1, 8'h04, 0);

        // R6 pointers
        op("R6", 1, 0, 8'h08, 32'hA5A5_0001);
        op("R6", 1, 0, 8'h0C, 32'h5A5A_0002);
        op("R6", 0, 1, 8'h08, 0);
        op("R6", 0, 1, 8'h0C, 0);

        // R7 outbound buffer
        for (int i = 0; i < NW; i++) op("R7", 1, 0, 8'(8'h80 + 4 * i), 32'h1111_0000 + 32'(i));
        op("R7", 0, 1, 8'h84, 0);
        op("R9", 1, 0, 8'h81, 32'hDEAD_BEEF);

        // R2 accepted command: indirect write, size 4, id 5, no ioc
        op("R2", 1, 0, 8'h00, 32'h0004_5000);
        op("R2", 0, 1, 8'h04, 0);
        op("R2", 0, 1, 8'h00, 0);

        // R3 command while busy
        op("R3", 1, 0, 8'h00, 32'h0004_2100);
        op("R3", 0, 1, 8'h04, 0);

        // R9 ignored accesses
        op("R9", 1, 0, 8'h04, 32'hFFFF_FFFF);
        op("R9", 0, 1, 8'h04, 0);
        op("R9", 0, 1, 8'h40, 0);
        op("R9", 1, 0, 8'h40, 32'h1234_5678);

        // R4 completion with error, no ioc so R5 expects no irq
        ctl_rbuf = {32'hD003, 32'hC002, 32'hB001, 32'hA000};
        op("R4", 0, 0, 8'h00, 0, 1'b1, 1'b1, 8'h3C, 8'h07);
        op("R4", 0, 1, 8'h04, 0);

        // R8 inbound buffer
        for (int i = 0; i < NW; i++) op("R8", 0, 1, 8'(8'h90 + 4 * i), 0);
        op("R8", 1, 0, 8'h94, 32'hFFFF_0000);
        op("R8", 0, 1, 8'h94, 0);

        // R5 command with ioc: indirect read, size 4, id 2
        op("R5", 1, 0, 8'h00, 32'h0004_2100);
        op("R5", 0, 1, 8'h04, 0);
        ctl_rbuf = {32'h4444, 32'h3333, 32'h2222, 32'h1234_ABCD};
        op("R5", 0, 0, 8'h00, 0, 1'b1, 1'b0, 8'h00, 8'h21);
        op("R5", 0, 1, 8'h90, 0);

        // R10 completion while idle
        ctl_rbuf = {4{32'hFFFF_FFFF}};
        op("R10", 0, 0, 8'h00, 0, 1'b1, 1'b1, 8'hEE, 8'hEE);
        op("R10", 0, 1, 8'h04, 0);
        op("R10", 0, 1, 8'h90, 0);

        // R3 overrun cleared by next accepted command, then R2 completion with a read in flight
        op("R3", 1, 0, 8'h00, 32'h0000_7000);
        op("R3", 1, 0, 8'h00, 32'h0000_8000);
        op("R3", 0, 1, 8'h04, 0, 1'b1, 1'b0, 8'h01, 8'h02);
        op("R3", 1, 0, 8'h00, 32'h0000_9100);
        op("R3", 0, 1, 8'h04, 0);
        op("R5", 0, 0, 8'h00, 0, 1'b1, 1'b0, 8'h00, 8'h03);
        op("R5", 0, 0, 8'h00, 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule